// File: doc/BRIEF.md
# Extended Control Register Read Unit

This block executes the instruction that reads one of the processor's extended control registers into the general-purpose result pair. A 64-bit index operand selects the register, and the unit returns its value in two 64-bit result registers. The first result takes the upper half of the value and the second takes the lower half. Two selectors are defined. Index 0 returns the enabled-state mask `ctl0_in`. Index 1 returns that mask ANDed with a live bitmap of the state components in use, but only when the in-use reporting feature is present.

Before it selects anything, the unit checks the execution conditions. An undefined-opcode fault is raised in any of three cases: the extended state-save feature is absent, the OS-enable control bit is clear, or a lock prefix is attached. A general-protection fault with error code zero is raised for a selector that is not supported. The outcome is registered. One cycle after the request, the unit reports either a result write or a fault code.

Top module: `ext_ctl_read_unit`

## Requirements
- R1: Only `idx_in[31:0]` selects the register; `idx_in[63:32]` has no effect on the outcome.
- R2: The upper 32 bits of the selected value appear on `res_hi_out[31:0]` and the lower 32 bits on `res_lo_out[31:0]`.
- R3: On a result write, bits 63:32 of both `res_hi_out` and `res_lo_out` are zero.
- R4: Selector 0 returns `ctl0_in`, provided no fault condition applies.
- R5: Selector 1 with `feat_inuse_rpt`=1 returns `ctl0_in & inuse_in`.
- R6: Selector 1 with `feat_inuse_rpt`=0, and any selector of 2 or above, give a general-protection fault with `fault_code`=2'b10 (error code zero).
- R7: `feat_save_ok`=0, `os_enable`=0 or `lock_pfx`=1 gives an undefined-opcode fault with `fault_code`=2'b01. This takes priority over any general-protection condition.
- R8: `done` pulses for one cycle in the cycle after `req_valid`. In that cycle exactly one of `res_we` and `fault_valid` is high.
- R9: When a fault is reported, `res_we` stays low and both result outputs keep their previous values.
- R10: Bits outside the parameter `IMPL_MASK` (default 64'h0000_0007_0000_02FF) read as zero in every returned value.
- R11: After reset all outputs are zero, and `fault_code` is 2'b00 whenever `fault_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Execute request strobe |
| idx_in | input | 64 | Index operand |
| feat_save_ok | input | 1 | Extended state-save feature supported |
| feat_inuse_rpt | input | 1 | In-use reporting via selector 1 supported |
| os_enable | input | 1 | OS-enable control bit |
| lock_pfx | input | 1 | Lock prefix present |
| ctl0_in | input | 64 | Enabled-state mask register |
| inuse_in | input | 64 | Live in-use component bitmap |
| done | output | 1 | Completion strobe |
| res_we | output | 1 | Result registers written |
| res_hi_out | output | 64 | First result: upper half of value, zero-extended |
| res_lo_out | output | 64 | Second result: lower half of value, zero-extended |
| fault_valid | output | 1 | Fault raised |
| fault_code | output | 2 | 01 undefined opcode, 10 general protection |

## Verification
Directed cases try selector 0 and selector 1 with the reporting flag both set and clear, and a selector of 2. Together these separate plain pass-through, the masking AND and the protection fault. Index operands with nonzero upper words show whether the upper word leaks into selection. Each undefined-opcode cause is applied alone and then together with an invalid selector, which exposes any error in fault priority. Random mixes of the selector, flags and data patterns, including values with bits outside the implemented mask, exercise half splitting and zeroing. The same mixes confirm that a fault leaves the last results untouched.

// File: rtl/ecr_pkg.sv
package ecr_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_UD   = 2'b01,
    FLT_GP   = 2'b10
  } flt_e;
endpackage

// File: rtl/ecr_fault_check.sv
module ecr_fault_check #(
  parameter int SEL_W = 32
) (
  input  logic [SEL_W-1:0] sel_idx,
  input  logic             feat_save_ok,
  input  logic             feat_inuse_rpt,
  input  logic             os_enable,
  input  logic             lock_pfx,
  output ecr_pkg::flt_e    code
);
  import ecr_pkg::*;
  logic ud_hit;
  logic gp_hit;

  always_comb begin
    ud_hit = !feat_save_ok || !os_enable || lock_pfx;
    // selector 0 always legal, selector 1 only with reporting support
    if (sel_idx == '0)
      gp_hit = 1'b0;
    else if (sel_idx == SEL_W'(1))
      gp_hit = !feat_inuse_rpt;
    else
      gp_hit = 1'b1;
    // undefined-opcode checks win over protection checks
    if (ud_hit)      code = FLT_UD;
    else if (gp_hit) code = FLT_GP;
    else             code = FLT_NONE;
  end
endmodule

// File: rtl/ecr_select.sv
module ecr_select #(
  parameter int          REG_W     = 64,
  parameter logic [63:0] IMPL_MASK = 64'h0000_0007_0000_02FF
) (
  input  logic             sel_one,
  input  logic [REG_W-1:0] ctl0,
  input  logic [REG_W-1:0] inuse,
  output logic [REG_W-1:0] value
);
  localparam logic [REG_W-1:0] MASK = IMPL_MASK[REG_W-1:0];
  logic [REG_W-1:0] raw;

  always_comb begin
    raw   = sel_one ? (ctl0 & inuse) : ctl0;
    value = raw & MASK;
  end
endmodule

// File: rtl/ecr_pack.sv
module ecr_pack #(
  parameter int REG_W = 64,
  parameter int RES_W = 64
) (
  input  logic [REG_W-1:0] value,
  output logic [RES_W-1:0] hi_word,
  output logic [RES_W-1:0] lo_word
);
  localparam int HALF = REG_W / 2;

  generate
    if (RES_W > HALF) begin : g_zext
      assign hi_word = {{(RES_W-HALF){1'b0}}, value[REG_W-1:HALF]};
      assign lo_word = {{(RES_W-HALF){1'b0}}, value[HALF-1:0]};
    end else begin : g_trunc
      assign hi_word = value[REG_W-1 -: RES_W];
      assign lo_word = value[RES_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ext_ctl_read_unit.sv
module ext_ctl_read_unit #(
  parameter int          IDX_W     = 64,
  parameter int          REG_W     = 64,
  parameter int          RES_W     = 64,
  parameter logic [63:0] IMPL_MASK = 64'h0000_0007_0000_02FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             feat_save_ok,
  input  logic             feat_inuse_rpt,
  input  logic             os_enable,
  input  logic             lock_pfx,
  input  logic [REG_W-1:0] ctl0_in,
  input  logic [REG_W-1:0] inuse_in,
  output logic             done,
  output logic             res_we,
  output logic [RES_W-1:0] res_hi_out,
  output logic [RES_W-1:0] res_lo_out,
  output logic             fault_valid,
  output logic [1:0]       fault_code
);
  import ecr_pkg::*;
  localparam int SEL_W = (IDX_W > 32) ? 32 : IDX_W;

  logic [SEL_W-1:0] sel_idx;
  flt_e             code_c;
  logic [REG_W-1:0] value_c;
  logic [RES_W-1:0] hi_c;
  logic [RES_W-1:0] lo_c;

  assign sel_idx = idx_in[SEL_W-1:0];

  ecr_fault_check #(.SEL_W(SEL_W)) u_chk (
    .sel_idx        (sel_idx),
    .feat_save_ok   (feat_save_ok),
    .feat_inuse_rpt (feat_inuse_rpt),
    .os_enable      (os_enable),
    .lock_pfx       (lock_pfx),
    .code           (code_c)
  );

  ecr_select #(.REG_W(REG_W), .IMPL_MASK(IMPL_MASK)) u_sel (
    .sel_one (sel_idx[0]),
    .ctl0    (ctl0_in),
    .inuse   (inuse_in),
    .value   (value_c)
  );

  ecr_pack #(.REG_W(REG_W), .RES_W(RES_W)) u_pack (
    .value   (value_c),
    .hi_word (hi_c),
    .lo_word (lo_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      res_we      <= 1'b0;
      fault_valid <= 1'b0;
      fault_code  <= 2'b00;
      res_hi_out  <= '0;
      res_lo_out  <= '0;
    end else begin
      done        <= req_valid;
      res_we      <= req_valid && (code_c == FLT_NONE);
      fault_valid <= req_valid && (code_c != FLT_NONE);
      fault_code  <= req_valid ? code_c : FLT_NONE;
      if (req_valid && (code_c == FLT_NONE)) begin
        res_hi_out <= hi_c;
        res_lo_out <= lo_c;
      end
    end
  end
endmodule

// File: rtl/ext_ctl_read_unit_chk.sv
module ext_ctl_read_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        feat_save_ok,
  input logic        os_enable,
  input logic        lock_pfx,
  input logic        done,
  input logic        res_we,
  input logic [63:0] res_hi_out,
  input logic [63:0] res_lo_out,
  input logic        fault_valid,
  input logic [1:0]  fault_code
);
  a_r8_done_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_we ^ fault_valid));
  a_r8_no_stray: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done && !res_we && !fault_valid);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    res_we |-> (res_hi_out[63:32] == 32'h0) && (res_lo_out[63:32] == 32'h0));
  a_r9_fault_holds: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> $stable(res_hi_out) && $stable(res_lo_out));
  a_r7_ud_first: assert property (@(posedge clk) disable iff (rst)
    req_valid && (!feat_save_ok || !os_enable || lock_pfx)
      |=> fault_valid && (fault_code == 2'b01));
  a_r11_code_idle: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |-> fault_code == 2'b00);
endmodule

bind ext_ctl_read_unit ext_ctl_read_unit_chk u_chk_bind (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .feat_save_ok (feat_save_ok),
  .os_enable    (os_enable),
  .lock_pfx     (lock_pfx),
  .done         (done),
  .res_we       (res_we),
  .res_hi_out   (res_hi_out),
  .res_lo_out   (res_lo_out),
  .fault_valid  (fault_valid),
  .fault_code   (fault_code)
);

// File: tb/ext_ctl_read_unit_tb_top.sv
module ext_ctl_read_unit_tb_top;
  localparam logic [63:0] IMPL = 64'h0000_0007_0000_02FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] idx_in = '0;
  logic        feat_save_ok = 1'b1;
  logic        feat_inuse_rpt = 1'b1;
  logic        os_enable = 1'b1;
  logic        lock_pfx = 1'b0;
  logic [63:0] ctl0_in = '0;
  logic [63:0] inuse_in = '0;
  logic        done, res_we, fault_valid;
  logic [63:0] res_hi_out, res_lo_out;
  logic [1:0]  fault_code;

  int checks = 0;
  int fails = 0;
  logic [63:0] model_hi = '0;
  logic [63:0] model_lo = '0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ext_ctl_read_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .idx_in(idx_in),
    .feat_save_ok(feat_save_ok), .feat_inuse_rpt(feat_inuse_rpt),
    .os_enable(os_enable), .lock_pfx(lock_pfx), .ctl0_in(ctl0_in),
    .inuse_in(inuse_in), .done(done), .res_we(res_we),
    .res_hi_out(res_hi_out), .res_lo_out(res_lo_out),
    .fault_valid(fault_valid), .fault_code(fault_code)
  );

  function automatic logic [1:0] exp_code(logic [63:0] idx, logic save, logic rpt,
                                          logic ose, logic lck);
    logic [31:0] s;
    s = idx[31:0];
    if (!save || !ose || lck) return 2'b01;
    if (s == 32'd0) return 2'b00;
    if (s == 32'd1 && rpt) return 2'b00;
    return 2'b10;
  endfunction

  function automatic logic [63:0] exp_val(logic [63:0] idx, logic [63:0] c0,
                                          logic [63:0] iu);
    logic [63:0] v;
    v = (idx[31:0] == 32'd1) ? (c0 & iu) : c0;
    return v & IMPL;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [63:0] idx, logic save, logic rpt,
                        logic ose, logic lck, logic [63:0] c0, logic [63:0] iu);
    logic [1:0]  ec;
    logic [63:0] v;
    @(negedge clk);
    idx_in = idx; feat_save_ok = save; feat_inuse_rpt = rpt;
    os_enable = ose; lock_pfx = lck; ctl0_in = c0; inuse_in = iu;
    req_valid = 1'b1;
    ec = exp_code(idx, save, rpt, ose, lck);
    v  = exp_val(idx, c0, iu);
    if (ec == 2'b00) begin
      model_hi = {32'h0, v[63:32]};
      model_lo = {32'h0, v[31:0]};
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "done R8", 64'(done), 64'd1);
    chk(req, "res_we R8", 64'(res_we), 64'(ec == 2'b00));
    chk(req, "fault_valid", 64'(fault_valid), 64'(ec != 2'b00));
    chk(req, "fault_code", 64'(fault_code), 64'(ec));
    chk(req, "res_hi_out R2", res_hi_out, model_hi);
    chk(req, "res_lo_out R2", res_lo_out, model_lo);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", "done", 64'(done), 64'd0);
    chk("R11", "res_we", 64'(res_we), 64'd0);
    chk("R11", "fault_valid", 64'(fault_valid), 64'd0);
    chk("R11", "fault_code", 64'(fault_code), 64'd0);
    chk("R11", "res_hi_out", res_hi_out, 64'd0);
    chk("R11", "res_lo_out", res_lo_out, 64'd0);
    // R4 selector 0, R10 mask drops unimplemented bits
    run_op("R4", 64'd0, 1, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
    run_op("R10", 64'd0, 1, 0, 1, 0, 64'h1234_5678_9ABC_DEF0, 64'h0);
    // R5 selector 1 with reporting
    run_op("R5", 64'd1, 1, 1, 1, 0, 64'h0000_0005_0000_02E7, 64'h0000_0004_0000_0123);
    // R6 selector 1 without reporting, and selector 2
    run_op("R6", 64'd1, 1, 0, 1, 0, 64'h3, 64'h3);
    run_op("R6", 64'd2, 1, 1, 1, 0, 64'h3, 64'h3);
    run_op("R6", 64'h0000_0000_8000_0000, 1, 1, 1, 0, 64'h3, 64'h3);
    // R1 upper word of the index ignored
    run_op("R1", 64'hFFFF_FFFF_0000_0000, 1, 1, 1, 0, 64'h0000_0002_0000_0007, 64'h0);
    run_op("R1", 64'h1234_5678_0000_0001, 1, 1, 1, 0, 64'h0000_0003_0000_00FF, 64'h0000_0001_0000_000F);
    // R7 each undefined-opcode cause, and priority over GP
    run_op("R7", 64'd0, 0, 1, 1, 0, 64'h7, 64'h7);
    run_op("R7", 64'd0, 1, 1, 0, 0, 64'h7, 64'h7);
    run_op("R7", 64'd0, 1, 1, 1, 1, 64'h7, 64'h7);
    run_op("R7", 64'd5, 1, 1, 1, 1, 64'h7, 64'h7);
    run_op("R7", 64'd1, 1, 0, 0, 0, 64'h7, 64'h7);
    // R9 fault keeps previous results; R3 upper halves zero
    run_op("R9", 64'd0, 1, 1, 1, 0, 64'h0000_0006_0000_0201, 64'h0);
    run_op("R9", 64'd3, 1, 1, 1, 0, 64'h0, 64'h0);
    chk("R3", "hi upper", {32'h0, res_hi_out[63:32]}, 64'h0);
    chk("R3", "lo upper", {32'h0, res_lo_out[63:32]}, 64'h0);
    // R8 no strobe without request
    @(negedge clk);
    chk("R8", "idle done", 64'(done), 64'd0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] idx;
      logic [2:0]  pick;
      pick = 3'($urandom_range(0, 7));
      idx = {$urandom(), 32'(pick < 3 ? 0 : (pick < 6 ? 1 : $urandom_range(2, 9)))};
      run_op("R2", idx, ($urandom_range(0, 9) != 0), 1'($urandom()),
             ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) == 0),
             {$urandom(), $urandom()}, {$urandom(), $urandom()});
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule